// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps an SDRAM device refreshed and decides when the refresh may take the command bus away from normal traffic. A free-running down-counter is reloaded from a programmable cycle count. Each time it runs out, the block marks one refresh as owed and blocks the access sequencer from starting anything new. It raises a request and waits for the sequencer to grant it, which the sequencer does once any burst in flight has finished.

Once granted, the block drives the SDRAM command pins itself. If the sequencer reports that some bank is open, the block first closes every bank with a precharge that has the all-banks address bit set. It then waits the precharge time and issues AUTO REFRESH. The device generates the refresh row internally, so no row address is driven. The block keeps traffic blocked for the programmed refresh recovery time. During the refresh command cycle it pulses a signal that tells the sequencer to discard its open-row records. It then releases the access path.

At most one refresh can be owed at a time. An expiry that arrives while one is still owed sets a sticky overflow flag and is dropped. A reload value of zero turns refresh generation off.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With a nonzero reload value P, an immediate grant and a fixed bank-open input, consecutive AUTO REFRESH commands are exactly P clock cycles apart.
- R2: With a reload value of zero, no command is driven, `acc_stall` stays low and no refresh becomes owed.
- R3: After an expiry, `acc_stall` stays high and `ref_req` stays high until `seq_gnt` is seen. No command is driven before the grant.
- R4: If `bank_open` is high when the grant is taken, the command that follows the grant is PRECHARGE-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. AUTO REFRESH then follows exactly `cfg_trp` cycles after it (with `cfg_trp` of 0 treated as 1).
- R5: If `bank_open` is low when the grant is taken, no precharge is issued, and AUTO REFRESH appears in the cycle after the last cycle in which `ref_req` is high.
- R6: AUTO REFRESH is encoded cs_n=0, ras_n=0, cas_n=0, we_n=1. `acc_stall` falls exactly `cfg_trc` cycles after it (with `cfg_trc` of 0 treated as 1), unless a new refresh is already owed.
- R7: `rows_forget` is high for exactly the one cycle in which AUTO REFRESH is driven, and at no other time.
- R8: An expiry while a refresh is still owed sets `ovf`, which stays set until reset. Only one refresh results from the expiries that arrived while it was owed.
- R9: During and right after reset: `acc_stall`, `ref_req`, `rows_forget`, `ovf` and `sd_a10` are 0, and cs_n, ras_n, cas_n and we_n are 1 (no operation).
- R10: A command (cs_n=0) is driven only while `acc_stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CNT_W | Cycles between refreshes; 0 turns refresh off |
| cfg_trp | input | TW | Precharge-to-refresh spacing in cycles |
| cfg_trc | input | TW | Refresh recovery time in cycles |
| seq_gnt | input | 1 | Sequencer has no access in flight and hands over the bus |
| bank_open | input | 1 | Sequencer holds at least one open row |
| ref_req | output | 1 | Refresh waiting for the grant |
| acc_stall | output | 1 | Sequencer must not start a new access |
| rows_forget | output | 1 | One-cycle pulse: discard all open-row records |
| ovf | output | 1 | Sticky: an expiry arrived while a refresh was still owed |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_a10 | output | 1 | Address bit 10, the all-banks flag of precharge |

## Verification
The refresh path is exercised with three reload values (25, 40, 781), with and without an open bank, and with spacing values at their minimum of 1 and above it. This separates an off-by-one in the timer from an off-by-one in the precharge gap or in the recovery window. A held-back grant shows whether the block truly waits for the sequencer and drives nothing in the meantime. A long hold under a short period shows that owed refreshes do not stack up and that overflow is reported. A zero reload value shows that refresh generation is fully off.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CNT_W = 16,
  parameter int TW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_trc,
  input  logic             seq_gnt,
  input  logic             bank_open,
  output logic             ref_req,
  output logic             acc_stall,
  output logic             rows_forget,
  output logic             ovf,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_a10
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_PRE, S_TRP, S_AREF, S_TRC} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [TW-1:0]    wcnt;
  logic             pend;
  logic             tick;

  assign tick = (cfg_period != '0) && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (cfg_period == '0)  cnt <= '0;
    else if (cnt < CNT_W'(2))   cnt <= cfg_period;
    else                        cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (tick)                pend <= 1'b1;
      else if (st == S_AREF)   pend <= 1'b0;
      if (tick && pend && st != S_AREF) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (pend) st <= S_WAIT;
        S_WAIT: if (seq_gnt) st <= bank_open ? S_PRE : S_AREF;
        S_PRE: begin
          if (cfg_trp < TW'(2)) st <= S_AREF;
          else begin
            wcnt <= cfg_trp - TW'(2);
            st   <= S_TRP;
          end
        end
        S_TRP: begin
          if (wcnt == '0) st <= S_AREF;
          else            wcnt <= wcnt - TW'(1);
        end
        S_AREF: begin
          if (cfg_trc < TW'(2)) st <= S_IDLE;
          else begin
            wcnt <= cfg_trc - TW'(2);
            st   <= S_TRC;
          end
        end
        S_TRC: begin
          if (wcnt == '0) st <= S_IDLE;
          else            wcnt <= wcnt - TW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ref_req     = (st == S_WAIT);
  assign acc_stall   = pend || (st != S_IDLE);
  assign rows_forget = (st == S_AREF);
  assign sd_cs_n     = !(st == S_PRE || st == S_AREF);
  assign sd_ras_n    = !(st == S_PRE || st == S_AREF);
  assign sd_cas_n    = !(st == S_AREF);
  assign sd_we_n     = !(st == S_PRE);
  assign sd_a10      = (st == S_PRE);

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cfg_period,
  input logic             seq_gnt,
  input logic             ref_req,
  input logic             acc_stall,
  input logic             rows_forget,
  input logic             ovf,
  input logic             sd_cs_n,
  input logic             sd_cas_n
);

  assert_cmd_needs_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stall |-> sd_cs_n);

  assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !seq_gnt) |=> ref_req);

  assert_pre_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && sd_cas_n) |-> $past(ref_req && seq_gnt));

  assert_forget_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rows_forget |=> !rows_forget);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_period == '0 && !acc_stall) |=> !acc_stall);

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .seq_gnt(seq_gnt),
  .ref_req(ref_req), .acc_stall(acc_stall), .rows_forget(rows_forget),
  .ovf(ovf), .sd_cs_n(sd_cs_n), .sd_cas_n(sd_cas_n)
);

// File: tb/sdram_refresh_sched_bench.sv
`timescale 1ns/1ps
module sdram_refresh_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_period = '0;
  logic [3:0]  cfg_trp = 4'd2, cfg_trc = 4'd2;
  logic        seq_gnt = 1'b0, bank_open = 1'b0;
  logic        ref_req, acc_stall, rows_forget, ovf;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;

  sdram_refresh_sched u_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .seq_gnt(seq_gnt), .bank_open(bank_open),
    .ref_req(ref_req), .acc_stall(acc_stall), .rows_forget(rows_forget),
    .ovf(ovf), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_a10(sd_a10)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  longint cyc = 0, last_ref = 0, prev_ref = 0, last_pre = 0, last_req = 0, last_rel = 0;
  int nref = 0, npre = 0, nstall = 0, a10_bad = 0, forget_bad = 0, cmd_bad = 0;
  logic stall_q = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n) begin
      prev_ref = last_ref; last_ref = cyc; nref++;
      if (!rows_forget) forget_bad++;
    end else if (rows_forget) forget_bad++;
    if (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) begin
      last_pre = cyc; npre++;
      if (!sd_a10) a10_bad++;
    end
    if (!sd_cs_n && !acc_stall) cmd_bad++;
    if (ref_req) last_req = cyc;
    if (stall_q && !acc_stall) last_rel = cyc;
    stall_q = acc_stall;
    if (acc_stall) nstall++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input int p, input int trp, input int trc, input bit op, input bit g);
    rst_n = 1'b0; cfg_period = 16'(p); cfg_trp = 4'(trp); cfg_trc = 4'(trc);
    bank_open = op; seq_gnt = g;
    step(3);
    nref = 0; npre = 0; nstall = 0; a10_bad = 0; forget_bad = 0; cmd_bad = 0;
    last_ref = 0; prev_ref = 0; last_pre = 0; last_req = 0; last_rel = 0;
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(40, 2, 2, 0, 1);
    rst_n = 1'b0;
    step(2);
    chk(!acc_stall && !ref_req && !rows_forget && !ovf, "R9 reset flags",
        {acc_stall, ref_req, rows_forget, ovf}, 0);
    chk(sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && !sd_a10, "R9 reset pins NOP",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10}, 5'b11110);
    rst_n = 1'b1;
    step(1);
    chk(!acc_stall && sd_cs_n && !ovf, "R9 after release", {acc_stall, sd_cs_n, ovf}, 3'b010);
  endtask

  task automatic t_off();
    do_reset(0, 2, 2, 1, 1);
    step(300);
    chk(nref == 0 && npre == 0, "R2 no command when off", nref + npre, 0);
    chk(nstall == 0, "R2 no stall when off", nstall, 0);
  endtask

  task automatic t_period(input int p, input bit op, input int trp, input int trc);
    do_reset(p, trp, trc, op, 1);
    for (int i = 0; i < 4 * p + 50 && nref < 3; i++) step(1);
    chk(nref >= 3, "R1 refreshes seen", nref, 3);
    chk(last_ref - prev_ref == p, "R1 refresh interval", last_ref - prev_ref, p);
    if (op) begin
      chk(last_ref - last_pre == trp, "R4 precharge to refresh gap", last_ref - last_pre, trp);
      chk(a10_bad == 0, "R4 all-banks bit", a10_bad, 0);
    end else begin
      chk(npre == 0, "R5 no precharge", npre, 0);
      chk(last_ref - last_req == 1, "R5 refresh after grant", last_ref - last_req, 1);
    end
    step(trc + 2);
    chk(last_rel - last_ref == trc, "R6 recovery window", last_rel - last_ref, trc);
    chk(forget_bad == 0, "R7 forget pulse with refresh only", forget_bad, 0);
    chk(cmd_bad == 0, "R10 commands only while stalled", cmd_bad, 0);
  endtask

  task automatic t_hold();
    int bad;
    bad = 0;
    do_reset(40, 2, 2, 1, 0);
    for (int i = 0; i < 100 && !ref_req; i++) step(1);
    chk(ref_req, "R3 request raised", ref_req, 1);
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (!(acc_stall && ref_req && sd_cs_n)) bad++;
    end
    chk(bad == 0, "R3 wait for grant, bus quiet", bad, 0);
    seq_gnt = 1'b1;
    step(1);
    chk(!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n && sd_a10, "R4 precharge-all after grant",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10}, 5'b00101);
  endtask

  task automatic t_ovf();
    do_reset(10, 2, 2, 0, 0);
    step(45);
    chk(ovf == 1'b1, "R8 overflow flag set", ovf, 1);
    chk(nref == 0, "R8 nothing before grant", nref, 0);
    seq_gnt = 1'b1;
    step(3);
    chk(nref == 1, "R8 single refresh for stacked expiries", nref, 1);
    step(20);
    chk(ovf == 1'b1, "R8 overflow sticky", ovf, 1);
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_off();
    t_period(40, 0, 2, 3);
    t_period(781, 1, 3, 2);
    t_period(25, 1, 1, 1);
    t_hold();
    t_ovf();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule